// File: doc/BRIEF.md
# Parallel Hyperbox Pattern Classifier

This block assigns a class to an attribute vector made of several unsigned parameters. It holds a programmable set of axis-aligned boxes. For each parameter, a box has an inclusive lower bound and an inclusive upper bound, and each box carries a class label. On every cycle where an input vector is presented, the block tests it against every bound of every box at the same time. It picks the winning box and registers the class code, a hit flag and the winning box index. These results appear one cycle later, together with a valid pulse.

Software or a training engine loads the bounds, labels and per-box enable bits through a single-cycle write port. The classifier can therefore be retargeted to a new set of decision regions at run time without any change to the logic. A write lands at the clock edge that samples it. A classification sampled at the same edge still uses the values held before that edge.

Top module: `hbox_classifier`

## Requirements
- R1: For each parameter, a box accepts the value when lower ≤ value ≤ upper, and both bounds count as inside. Parameter p of the vector sits at bits inVec[p*VAL_W +: VAL_W].
- R2: A box contains the vector only when every one of its parameters is accepted. One parameter out of range rejects that box.
- R3: When several boxes contain the vector, the box with the lowest index wins, and its label and index are reported.
- R4: When no box contains the vector, outVld still pulses, with outHit = 0, outClass = 0 and outBox = 0.
- R5: A box whose enable bit is clear never contains any vector. Every box comes out of reset disabled.
- R6: outVld pulses exactly one cycle after each cycle with inVld high, and is low otherwise. outHit, outClass and outBox hold their values through cycles that have no input.
- R7: Programming uses a write enable plus the fields wrBox, wrAttr, wrSel and wrData. The wrSel codes are:
  - 0 writes the lower bound of parameter wrAttr.
  - 1 writes the upper bound of parameter wrAttr.
  - 2 writes the label, taken from wrData[LBL_W-1:0].
  - 3 writes the enable bit, taken from wrData[0].
  For codes 2 and 3, wrAttr is ignored.
- R8: A write sampled at the same edge as an input vector does not affect that vector's result. It applies from the next classification on.
- R9: After reset, outVld, outHit, outClass and outBox are all zero.
- R10: A box with lower > upper on any parameter never contains a vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inVld | input | 1 | Input vector present this cycle |
| inVec | input | NUM_ATTR*VAL_W | Packed attribute vector |
| wrEn | input | 1 | Programming write strobe |
| wrBox | input | BOX_IW | Box index to write |
| wrAttr | input | ATTR_IW | Parameter index for bound writes |
| wrSel | input | 2 | Field select: 0 lower, 1 upper, 2 label, 3 enable |
| wrData | input | VAL_W | Write data |
| outVld | output | 1 | Result valid pulse |
| outHit | output | 1 | Some enabled box contains the vector |
| outClass | output | LBL_W | Label of the winning box, 0 on reject |
| outBox | output | BOX_IW | Index of the winning box, 0 on reject |

## Verification
On every cycle, the assertions check the one-cycle valid timing and the holding of result fields while idle. They also check that the reported box index is in range, that reject results are zeroed, and that no hit can appear before any box has been enabled. Only the directed scenarios can confirm the actual decisions: inclusive bound edges, one parameter out of range, lowest-index priority among overlapping boxes, disabling, inverted bounds, and a write colliding with a classification. Those scenarios compare the results against an independent reference model of the boxes.

// File: rtl/hbox_pkg.sv
package hbox_pkg;

  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_HI  = 2'd1,
    SEL_LBL = 2'd2,
    SEL_EN  = 2'd3
  } hbox_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldLo;
    logic ldHi;
    logic ldLbl;
    logic ldEn;
    logic capture;
  } hbox_ctl_t;

endpackage

// File: rtl/hbox_ctrl.sv
module hbox_ctrl
  import hbox_pkg::*;
(
  input  logic      inVld,
  input  logic      wrEn,
  input  logic [1:0] wrSel,
  output hbox_ctl_t ctl
);

  hbox_sel_e sel;

  always_comb begin
    sel         = hbox_sel_e'(wrSel);
    ctl         = '0;
    ctl.capture = inVld;
    if (wrEn) begin
      unique case (sel)
        SEL_LO:  ctl.ldLo  = 1'b1;
        SEL_HI:  ctl.ldHi  = 1'b1;
        SEL_LBL: ctl.ldLbl = 1'b1;
        SEL_EN:  ctl.ldEn  = 1'b1;
        default: ctl       = ctl;
      endcase
    end
  end

endmodule

// File: rtl/hbox_match.sv
module hbox_match #(
  parameter int NUM_ATTR = 4,
  parameter int VAL_W    = 8
) (
  input  logic [NUM_ATTR-1:0][VAL_W-1:0] vec,
  input  logic [NUM_ATTR-1:0][VAL_W-1:0] lo,
  input  logic [NUM_ATTR-1:0][VAL_W-1:0] hi,
  input  logic                           en,
  output logic                           hit
);

  logic [NUM_ATTR-1:0] inWin;

  for (genvar p = 0; p < NUM_ATTR; p++) begin : g_attr
    assign inWin[p] = (vec[p] >= lo[p]) && (vec[p] <= hi[p]);
  end

  assign hit = en && (&inWin);

endmodule

// File: rtl/hbox_datapath.sv
module hbox_datapath
  import hbox_pkg::*;
#(
  parameter int NUM_BOX  = 8,
  parameter int NUM_ATTR = 4,
  parameter int VAL_W    = 8,
  parameter int LBL_W    = 3,
  localparam int BOX_IW  = (NUM_BOX  > 1) ? $clog2(NUM_BOX)  : 1,
  localparam int ATTR_IW = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  hbox_ctl_t                 ctl,
  input  logic [NUM_ATTR*VAL_W-1:0] inVec,
  input  logic [BOX_IW-1:0]         wrBox,
  input  logic [ATTR_IW-1:0]        wrAttr,
  input  logic [VAL_W-1:0]          wrData,
  output logic                      outVld,
  output logic                      outHit,
  output logic [LBL_W-1:0]          outClass,
  output logic [BOX_IW-1:0]         outBox
);

  logic [NUM_ATTR-1:0][VAL_W-1:0] loMem  [NUM_BOX];
  logic [NUM_ATTR-1:0][VAL_W-1:0] hiMem  [NUM_BOX];
  logic [LBL_W-1:0]               lblMem [NUM_BOX];
  logic [NUM_BOX-1:0]             enMem;
  logic [NUM_ATTR-1:0][VAL_W-1:0] vecArr;
  logic [NUM_BOX-1:0]             boxHit;
  logic                           anyHit;
  logic [BOX_IW-1:0]              winIdx;

  assign vecArr = inVec;

  // region storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BOX; b++) begin
        loMem[b]  <= '0;
        hiMem[b]  <= '0;
        lblMem[b] <= '0;
      end
      enMem <= '0;
    end else begin
      if (ctl.ldLo)  loMem[wrBox][wrAttr] <= wrData;
      if (ctl.ldHi)  hiMem[wrBox][wrAttr] <= wrData;
      if (ctl.ldLbl) lblMem[wrBox]        <= wrData[LBL_W-1:0];
      if (ctl.ldEn)  enMem[wrBox]         <= wrData[0];
    end
  end

  // one window comparator set per box
  for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
    hbox_match #(
      .NUM_ATTR(NUM_ATTR),
      .VAL_W   (VAL_W)
    ) u_match (
      .vec(vecArr),
      .lo (loMem[b]),
      .hi (hiMem[b]),
      .en (enMem[b]),
      .hit(boxHit[b])
    );
  end

  // lowest index wins
  always_comb begin
    anyHit = |boxHit;
    winIdx = '0;
    for (int b = NUM_BOX - 1; b >= 0; b--) begin
      if (boxHit[b]) winIdx = BOX_IW'(b);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVld   <= 1'b0;
      outHit   <= 1'b0;
      outClass <= '0;
      outBox   <= '0;
    end else begin
      outVld <= ctl.capture;
      if (ctl.capture) begin
        outHit   <= anyHit;
        outClass <= anyHit ? lblMem[winIdx] : '0;
        outBox   <= anyHit ? winIdx : '0;
      end
    end
  end

endmodule

// File: rtl/hbox_classifier.sv
module hbox_classifier
  import hbox_pkg::*;
#(
  parameter int NUM_BOX  = 8,
  parameter int NUM_ATTR = 4,
  parameter int VAL_W    = 8,
  parameter int LBL_W    = 3,
  localparam int BOX_IW  = (NUM_BOX  > 1) ? $clog2(NUM_BOX)  : 1,
  localparam int ATTR_IW = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inVld,
  input  logic [NUM_ATTR*VAL_W-1:0] inVec,
  input  logic                      wrEn,
  input  logic [BOX_IW-1:0]         wrBox,
  input  logic [ATTR_IW-1:0]        wrAttr,
  input  logic [1:0]                wrSel,
  input  logic [VAL_W-1:0]          wrData,
  output logic                      outVld,
  output logic                      outHit,
  output logic [LBL_W-1:0]          outClass,
  output logic [BOX_IW-1:0]         outBox
);

  hbox_ctl_t ctl;

  hbox_ctrl u_ctrl (
    .inVld(inVld),
    .wrEn (wrEn),
    .wrSel(wrSel),
    .ctl  (ctl)
  );

  hbox_datapath #(
    .NUM_BOX (NUM_BOX),
    .NUM_ATTR(NUM_ATTR),
    .VAL_W   (VAL_W),
    .LBL_W   (LBL_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inVec   (inVec),
    .wrBox   (wrBox),
    .wrAttr  (wrAttr),
    .wrData  (wrData),
    .outVld  (outVld),
    .outHit  (outHit),
    .outClass(outClass),
    .outBox  (outBox)
  );

endmodule

// File: rtl/hbox_chk.sv
module hbox_chk #(
  parameter int NUM_BOX = 8,
  parameter int LBL_W   = 3,
  parameter int BOX_IW  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inVld,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic              wrBit0,
  input logic              outVld,
  input logic              outHit,
  input logic [LBL_W-1:0]  outClass,
  input logic [BOX_IW-1:0] outBox
);

  logic everEnabled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  everEnabled <= 1'b0;
    else if (wrEn && wrSel == 2'd3 && wrBit0)   everEnabled <= 1'b1;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> outVld) else $error("valid missing");                     // R6
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> !outVld) else $error("spurious valid");                  // R6
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> ($stable(outHit) && $stable(outClass) && $stable(outBox)))
    else $error("result changed while idle");                           // R6
  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && !outHit) |-> (outClass == '0 && outBox == '0))
    else $error("reject not zeroed");                                   // R4
  AST_BOX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outHit |-> (int'(outBox) < NUM_BOX)) else $error("box out of range"); // R3
  AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !everEnabled |-> !outHit) else $error("hit with all boxes off");    // R5

endmodule

bind hbox_classifier hbox_chk #(
  .NUM_BOX(NUM_BOX),
  .LBL_W  (LBL_W),
  .BOX_IW (BOX_IW)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inVld   (inVld),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .wrBit0  (wrData[0]),
  .outVld  (outVld),
  .outHit  (outHit),
  .outClass(outClass),
  .outBox  (outBox)
);

// File: tb/tb_hbox_classifier.sv
module tb_hbox_classifier;

  localparam int NB = 8;
  localparam int NA = 4;
  localparam int VW = 8;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inVld = 1'b0;
  logic [NA*VW-1:0] inVec = '0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrBox = '0;
  logic [1:0]    wrAttr = '0;
  logic [1:0]    wrSel = '0;
  logic [VW-1:0] wrData = '0;
  logic          outVld, outHit;
  logic [LW-1:0] outClass;
  logic [2:0]    outBox;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  // reference model
  int mLo [NB][NA];
  int mHi [NB][NA];
  int mLbl[NB];
  bit mEn [NB];

  hbox_classifier dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inVec(inVec),
    .wrEn(wrEn), .wrBox(wrBox), .wrAttr(wrAttr), .wrSel(wrSel), .wrData(wrData),
    .outVld(outVld), .outHit(outHit), .outClass(outClass), .outBox(outBox)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int modelWin(int v[NA]);
    for (int b = 0; b < NB; b++) begin
      bit ok = mEn[b];
      for (int p = 0; p < NA; p++)
        if (v[p] < mLo[b][p] || v[p] > mHi[b][p]) ok = 1'b0;
      if (ok) return b;
    end
    return -1;
  endfunction

  task automatic wrReg(int box, int attr, int sel, int data);
    @(negedge clk);
    wrEn = 1'b1; wrBox = 3'(box); wrAttr = 2'(attr); wrSel = 2'(sel); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
    case (sel)
      0: mLo[box][attr] = data;
      1: mHi[box][attr] = data;
      2: mLbl[box] = data % (1 << LW);
      default: mEn[box] = data[0];
    endcase
  endtask

  task automatic setBox(int box, int lo[NA], int hi[NA], int lbl);
    for (int p = 0; p < NA; p++) begin
      wrReg(box, p, 0, lo[p]);
      wrReg(box, p, 1, hi[p]);
    end
    wrReg(box, 0, 2, lbl);
    wrReg(box, 0, 3, 1);
  endtask

  task automatic checkResult(string req, int w);
    chk(req, int'(outVld), 1);
    chk(req, int'(outHit), (w >= 0) ? 1 : 0);
    chk(req, int'(outClass), (w >= 0) ? mLbl[w] : 0);
    chk(req, int'(outBox), (w >= 0) ? w : 0);
  endtask

  task automatic classify(string req, int v[NA]);
    int w = modelWin(v);
    @(negedge clk);
    inVld = 1'b1;
    for (int p = 0; p < NA; p++) inVec[p*VW +: VW] = 8'(v[p]);
    @(negedge clk);
    inVld = 1'b0;
    checkResult(req, w);
  endtask

  task automatic testReset();
    chk("R9", int'(outVld), 0);
    chk("R9", int'(outHit), 0);
    chk("R9", int'(outClass), 0);
    chk("R9", int'(outBox), 0);
    classify("R5", '{5, 5, 5, 5});
    chk("R5 reset disabled", int'(outHit), 0);
    classify("R4", '{0, 0, 0, 0});
  endtask

  task automatic testWindow();
    setBox(2, '{10, 20, 30, 40}, '{50, 60, 70, 80}, 5);
    classify("R1 inside", '{30, 40, 50, 60});
    chk("R1 inside hit", int'(outBox), 2);
    classify("R1 lower edge", '{10, 20, 30, 40});
    chk("R1 lower edge hit", int'(outHit), 1);
    classify("R1 upper edge", '{50, 60, 70, 80});
    chk("R1 upper edge hit", int'(outHit), 1);
    classify("R2 one below", '{30, 40, 50, 39});
    chk("R2 one below reject", int'(outHit), 0);
    classify("R2 one above", '{51, 40, 50, 60});
    chk("R2 one above reject", int'(outHit), 0);
  endtask

  task automatic testPriority();
    setBox(0, '{25, 35, 45, 55}, '{35, 45, 55, 65}, 1);
    classify("R3 overlap", '{30, 40, 50, 60});
    chk("R3 lowest wins", int'(outBox), 0);
    chk("R3 lowest label", int'(outClass), 1);
    classify("R3 only higher", '{12, 22, 32, 42});
    chk("R3 higher alone", int'(outBox), 2);
    wrReg(0, 0, 3, 0);
    classify("R5 disabled", '{30, 40, 50, 60});
    chk("R5 disabled skipped", int'(outBox), 2);
  endtask

  task automatic testHold();
    logic [LW-1:0] c;
    logic [2:0] b;
    classify("R6", '{30, 40, 50, 60});
    c = outClass; b = outBox;
    repeat (3) @(negedge clk);
    chk("R6 valid drops", int'(outVld), 0);
    chk("R6 class holds", int'(outClass), int'(c));
    chk("R6 box holds", int'(outBox), int'(b));
  endtask

  task automatic testCollide();
    int v[NA] = '{30, 40, 50, 60};
    int w = modelWin(v);
    @(negedge clk);
    inVld = 1'b1;
    for (int p = 0; p < NA; p++) inVec[p*VW +: VW] = 8'(v[p]);
    wrEn = 1'b1; wrBox = 3'd2; wrAttr = 2'd0; wrSel = 2'd3; wrData = 8'd0;
    @(negedge clk);
    inVld = 1'b0; wrEn = 1'b0;
    checkResult("R8 old value", w);
    chk("R8 still hits", int'(outHit), 1);
    mEn[2] = 1'b0;
    classify("R8 applied", v);
    chk("R8 now rejects", int'(outHit), 0);
  endtask

  task automatic testInverted();
    setBox(6, '{100, 0, 0, 0}, '{50, 255, 255, 255}, 6);
    classify("R10 inverted", '{75, 9, 9, 9});
    chk("R10 never hits", int'(outHit), 0);
    setBox(7, '{0, 0, 0, 0}, '{255, 255, 255, 255}, 7);
    classify("R1 full range max", '{255, 255, 255, 255});
    chk("R1 full range box", int'(outBox), 7);
    wrReg(7, 0, 2, 8'hFB);
    classify("R7 label low bits", '{1, 2, 3, 4});
    chk("R7 label", int'(outClass), 3);
    wrReg(7, 3, 0, 9);
    classify("R7 lower write", '{1, 2, 3, 8});
    chk("R7 lower applied", int'(outHit), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      mLbl[b] = 0; mEn[b] = 1'b0;
      for (int p = 0; p < NA; p++) begin mLo[b][p] = 0; mHi[b][p] = 0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWindow();
    testPriority();
    testHold();
    testCollide();
    testInverted();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    #2000000;
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule